// File: doc/BRIEF.md
# Write-Buffer-Aware Page Replacement Selector

This block picks the main-memory frame to give up when the host takes a page fault, in a system whose backing store is flash behind a clustered write buffer. For every frame it holds a recency rank, a dirty bit and the logical flash block the page belongs to. On a fault it walks the frames from least to most recently used, one frame per cycle. For each frame it asks the write buffer two questions: does the frame's block already own a cluster there, and would the buffer accept a new cluster right now.

A clean frame is taken at once, with no write-back. A dirty frame is taken with a write-back request unless two things are both true: its block has no resident cluster, and the buffer refuses new clusters. In that case the frame is passed over and the walk moves one step toward the most recently used end. If every frame is passed over, the least recently used frame is taken anyway, with a write-back, so a fault always finishes. The effect is that write-backs are reordered to suit what the buffer already holds.

The host reports hits (touch), installs a page into a frame after a fault (fill), and reports finished write-backs. Page data, the memory bus and the buffer's own policy live outside this block.

Top module: `page_evict_sel`

## Requirements
- R1: After reset every frame is clean, the recency order from least to most recent is frame 0, 1, ..., NUM_FRAMES-1, and done_o, busy_o and writeback_o are low.
- R2: An accepted touch or fill moves the named frame to the most-recent position. Frames that were more recent than it each move down one place, and the relative order of all other frames is kept.
- R3: A touch with touch_write_i high sets the frame's dirty bit, and a touch with it low leaves the bit unchanged. A fill stores fill_blk_i as the frame's block and sets the dirty bit to fill_write_i.
- R4: An accepted fault starts a walk at the least recently used frame and examines one frame per cycle. When the frame at recency position k (0 = least recent) is chosen, done_o is high for exactly one cycle, k+1 clock edges after the edge that sampled fault_i. wb_query_blk_o gives the block of the frame being examined.
- R5: A clean frame under examination is chosen with writeback_o low.
- R6: A dirty frame whose block has a resident cluster (wb_has_cluster_i high) is chosen with writeback_o high.
- R7: A dirty frame whose block has no cluster, while wb_can_create_i is high, is chosen with writeback_o high.
- R8: A dirty frame is skipped when wb_has_cluster_i and wb_can_create_i are both low, and the walk moves on to the next more recent frame.
- R9: If every frame is skipped, the least recently used frame is chosen with writeback_o high, NUM_FRAMES edges after the edge that sampled the fault.
- R10: wb_done_i clears the dirty bit of wb_done_frame_i.
- R11: While busy_o is high, touch_i, fill_i and fault_i are ignored. When fill_i and touch_i arrive together, only the fill takes effect.
- R12: victim_blk_o gives the block of victim_frame_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_i | input | 1 | Hit on a resident frame |
| touch_frame_i | input | IDX_W | Frame that was hit |
| touch_write_i | input | 1 | Hit was a write |
| fill_i | input | 1 | New page installed into a frame |
| fill_frame_i | input | IDX_W | Frame being filled |
| fill_blk_i | input | BLK_W | Logical flash block of the new page |
| fill_write_i | input | 1 | New page starts dirty |
| wb_done_i | input | 1 | A write-back has completed |
| wb_done_frame_i | input | IDX_W | Frame whose write-back completed |
| fault_i | input | 1 | Page fault, start a victim walk |
| busy_o | output | 1 | Walk in progress |
| wb_query_blk_o | output | BLK_W | Block of the frame under examination |
| wb_has_cluster_i | input | 1 | Queried block has a cluster in the write buffer |
| wb_can_create_i | input | 1 | Write buffer accepts a new cluster |
| done_o | output | 1 | One-cycle pulse, victim chosen |
| victim_frame_o | output | IDX_W | Chosen frame |
| victim_blk_o | output | BLK_W | Block of the chosen frame |
| writeback_o | output | 1 | Chosen frame must be written back |

## Verification
The bench sets up dirty frames whose blocks lead the walk past several skipped candidates before one is accepted, then checks both the chosen frame and the cycle at which done_o rises. A design that skipped too eagerly, or stopped too early, would pick the wrong frame or report it at the wrong cycle. When every frame is deferred, the bench checks that the least recently used frame comes back with a write-back; a design that wrapped around, or never finished, would fail there. A touch sent in the middle of a walk would change which frame is least recent if it were taken, so the forced pick also shows whether mid-walk touches are ignored. Completed write-backs, and fills of clean pages, are seen through later walks that now accept those frames with no write-back request.

// File: rtl/page_evict_pkg.sv
package page_evict_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;
endpackage

// File: rtl/lru_rank.sv
module lru_rank #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_frame_i,
  input  logic [IDX_W-1:0] query_rank_i,
  output logic [IDX_W-1:0] query_frame_o,
  output logic [IDX_W-1:0] lru_frame_o
);
  localparam logic [IDX_W-1:0] MRU = IDX_W'(NUM_FRAMES - 1);

  logic [IDX_W-1:0] rank_q [NUM_FRAMES];
  logic [IDX_W-1:0] old_rank;
  logic [NUM_FRAMES-1:0] q_match, lru_match;

  assign old_rank = rank_q[touch_frame_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_FRAMES; g++) rank_q[g] <= IDX_W'(g);
    end else if (touch_i) begin
      for (int g = 0; g < NUM_FRAMES; g++) begin
        if (IDX_W'(g) == touch_frame_i) rank_q[g] <= MRU;
        else if (rank_q[g] > old_rank) rank_q[g] <= rank_q[g] - IDX_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_match
    assign q_match[g]   = (rank_q[g] == query_rank_i);
    assign lru_match[g] = (rank_q[g] == '0);
  end

  always_comb begin
    query_frame_o = '0;
    lru_frame_o   = '0;
    for (int g = 0; g < NUM_FRAMES; g++) begin
      if (q_match[g])   query_frame_o = IDX_W'(g);
      if (lru_match[g]) lru_frame_o   = IDX_W'(g);
    end
  end

  // R2
  rank_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lru_match) == 1 && $countones(q_match) == 1);
  // R2
  touch_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> lru_frame_o != $past(touch_frame_i) || NUM_FRAMES == 1);
endmodule

// File: rtl/frame_state.sv
module frame_state #(
  parameter int NUM_FRAMES = 8,
  parameter int BLK_W = 4,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_frame_i,
  input  logic             touch_write_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_frame_i,
  input  logic [BLK_W-1:0] fill_blk_i,
  input  logic             fill_write_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_frame_i,
  input  logic [IDX_W-1:0] cand_frame_i,
  input  logic [IDX_W-1:0] victim_frame_i,
  output logic             cand_dirty_o,
  output logic [BLK_W-1:0] cand_blk_o,
  output logic [BLK_W-1:0] victim_blk_o
);
  logic [NUM_FRAMES-1:0] dirty_q;
  logic [BLK_W-1:0]      blk_q [NUM_FRAMES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= '0;
      for (int g = 0; g < NUM_FRAMES; g++) blk_q[g] <= '0;
    end else begin
      if (clr_i) dirty_q[clr_frame_i] <= 1'b0;
      if (touch_i && touch_write_i) dirty_q[touch_frame_i] <= 1'b1;
      if (fill_i) begin
        dirty_q[fill_frame_i] <= fill_write_i;
        blk_q[fill_frame_i]   <= fill_blk_i;
      end
    end
  end

  assign cand_dirty_o = dirty_q[cand_frame_i];
  assign cand_blk_o   = blk_q[cand_frame_i];
  assign victim_blk_o = blk_q[victim_frame_i];

  // R10
  wb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(touch_i && touch_write_i && touch_frame_i == clr_frame_i)
          && !(fill_i && fill_frame_i == clr_frame_i)
    |=> !dirty_q[$past(clr_frame_i)]);
endmodule

// File: rtl/victim_scan.sv
module victim_scan
  import page_evict_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic [IDX_W-1:0] cand_frame_i,
  input  logic             cand_dirty_i,
  input  logic             has_cluster_i,
  input  logic             can_create_i,
  input  logic [IDX_W-1:0] lru_frame_i,
  output logic [IDX_W-1:0] scan_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_frame_o,
  output logic             writeback_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  scan_st_e         state_q;
  logic [IDX_W-1:0] idx_q;
  logic             defer;

  assign defer      = cand_dirty_i && !has_cluster_i && !can_create_i;
  assign scan_idx_o = idx_q;
  assign busy_o     = (state_q == ST_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      idx_q          <= '0;
      done_o         <= 1'b0;
      victim_frame_o <= '0;
      writeback_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fault_i) begin
          state_q <= ST_SCAN;
          idx_q   <= '0;
        end
        ST_SCAN: begin
          if (!defer) begin
            done_o         <= 1'b1;
            victim_frame_o <= cand_frame_i;
            writeback_o    <= cand_dirty_i;
            state_q        <= ST_IDLE;
          end else if (idx_q == LAST) begin
            // every candidate deferred: force LRU out
            done_o         <= 1'b1;
            victim_frame_o <= lru_frame_i;
            writeback_o    <= 1'b1;
            state_q        <= ST_IDLE;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  clean_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !cand_dirty_i |=> done_o && !writeback_o);
  // R6 R7
  dirty_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cand_dirty_i && (has_cluster_i || can_create_i) |=> done_o && writeback_o);
  // R8
  defer_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && defer && idx_q != LAST |=> busy_o && !done_o && idx_q == IDX_W'($past(idx_q) + IDX_W'(1)));
  // R9
  force_lru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && defer && idx_q == LAST |=> done_o && writeback_o && victim_frame_o == $past(lru_frame_i));
endmodule

// File: rtl/page_evict_sel.sv
module page_evict_sel #(
  parameter int NUM_FRAMES = 8,
  parameter int BLK_W = 4,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_frame_i,
  input  logic             touch_write_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_frame_i,
  input  logic [BLK_W-1:0] fill_blk_i,
  input  logic             fill_write_i,
  input  logic             wb_done_i,
  input  logic [IDX_W-1:0] wb_done_frame_i,
  input  logic             fault_i,
  output logic             busy_o,
  output logic [BLK_W-1:0] wb_query_blk_o,
  input  logic             wb_has_cluster_i,
  input  logic             wb_can_create_i,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_frame_o,
  output logic [BLK_W-1:0] victim_blk_o,
  output logic             writeback_o
);
  logic             fill_en, touch_en, fault_en, rank_upd;
  logic [IDX_W-1:0] rank_frame, scan_idx, cand_frame, lru_frame;
  logic             cand_dirty;

  assign fill_en    = fill_i && !busy_o;
  assign touch_en   = touch_i && !fill_i && !busy_o;
  assign fault_en   = fault_i && !busy_o;
  assign rank_upd   = fill_en || touch_en;
  assign rank_frame = fill_en ? fill_frame_i : touch_frame_i;

  lru_rank #(.NUM_FRAMES(NUM_FRAMES)) u_rank (
    .clk_i, .rst_ni,
    .touch_i       (rank_upd),
    .touch_frame_i (rank_frame),
    .query_rank_i  (scan_idx),
    .query_frame_o (cand_frame),
    .lru_frame_o   (lru_frame)
  );

  frame_state #(.NUM_FRAMES(NUM_FRAMES), .BLK_W(BLK_W)) u_state (
    .clk_i, .rst_ni,
    .touch_i        (touch_en),
    .touch_frame_i,
    .touch_write_i,
    .fill_i         (fill_en),
    .fill_frame_i,
    .fill_blk_i,
    .fill_write_i,
    .clr_i          (wb_done_i),
    .clr_frame_i    (wb_done_frame_i),
    .cand_frame_i   (cand_frame),
    .victim_frame_i (victim_frame_o),
    .cand_dirty_o   (cand_dirty),
    .cand_blk_o     (wb_query_blk_o),
    .victim_blk_o
  );

  victim_scan #(.NUM_FRAMES(NUM_FRAMES)) u_scan (
    .clk_i, .rst_ni,
    .fault_i        (fault_en),
    .cand_frame_i   (cand_frame),
    .cand_dirty_i   (cand_dirty),
    .has_cluster_i  (wb_has_cluster_i),
    .can_create_i   (wb_can_create_i),
    .lru_frame_i    (lru_frame),
    .scan_idx_o     (scan_idx),
    .busy_o,
    .done_o,
    .victim_frame_o,
    .writeback_o
  );

  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && fault_i && !done_o |=> !done_o || busy_o == 1'b0);
  // R12
  wb_only_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(writeback_o) |-> done_o);
endmodule

// File: tb/page_evict_sel_tb.sv
module page_evict_sel_tb;
  localparam int N = 8;
  localparam int BW = 4;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic touch = 0, touch_wr = 0, fill = 0, fill_wr = 0, wbd = 0, fault = 0, can = 0;
  logic [IW-1:0] touch_fr = 0, fill_fr = 0, wbd_fr = 0;
  logic [BW-1:0] fill_blk = 0;
  logic [(1<<BW)-1:0] cl_mask = '0;
  logic busy, done, wbo, has_cl;
  logic [BW-1:0] qblk, vblk;
  logic [IW-1:0] vfr;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign has_cl = cl_mask[qblk];

  page_evict_sel #(.NUM_FRAMES(N), .BLK_W(BW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .touch_i(touch), .touch_frame_i(touch_fr), .touch_write_i(touch_wr),
    .fill_i(fill), .fill_frame_i(fill_fr), .fill_blk_i(fill_blk), .fill_write_i(fill_wr),
    .wb_done_i(wbd), .wb_done_frame_i(wbd_fr), .fault_i(fault),
    .busy_o(busy), .wb_query_blk_o(qblk),
    .wb_has_cluster_i(has_cl), .wb_can_create_i(can),
    .done_o(done), .victim_frame_o(vfr), .victim_blk_o(vblk), .writeback_o(wbo));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_touch(input int f, input bit w);
    @(negedge clk); touch = 1; touch_fr = IW'(f); touch_wr = w;
    @(negedge clk); touch = 0; touch_wr = 0;
  endtask

  task automatic do_fill(input int f, input int b, input bit w);
    @(negedge clk); fill = 1; fill_fr = IW'(f); fill_blk = BW'(b); fill_wr = w;
    @(negedge clk); fill = 0;
  endtask

  task automatic do_wbdone(input int f);
    @(negedge clk); wbd = 1; wbd_fr = IW'(f);
    @(negedge clk); wbd = 0;
  endtask

  // fault walk; lat counts negedges after the fault was driven; busy_touch
  // sends a touch of frame tf in the first busy cycle
  task automatic walk(input string req, input logic [(1<<BW)-1:0] m, input bit c,
                      input int exp_fr, input int exp_wb, input int exp_blk,
                      input int exp_lat, input bit busy_touch, input int tf);
    int lat;
    cl_mask = m; can = c;
    @(negedge clk); fault = 1;
    @(negedge clk); fault = 0; lat = 1;
    if (busy_touch) begin touch = 1; touch_fr = IW'(tf); fault = 1; end
    while (!done && lat < 40) begin
      @(negedge clk); lat++;
      touch = 0; fault = 0;
    end
    chk(req, "victim frame", int'(vfr), exp_fr);
    chk(req, "writeback", int'(wbo), exp_wb);
    chk(req, "victim block", int'(vblk), exp_blk);
    chk(req, "latency", lat, exp_lat);
    @(negedge clk);
    chk("R4", "done one cycle", int'(done), 0);
  endtask

  task automatic t_reset;
    chk("R1", "done at reset", int'(done), 0);
    chk("R1", "busy at reset", int'(busy), 0);
    chk("R1", "writeback at reset", int'(wbo), 0);
    // R1 R5 R4: all clean, frame 0 least recent, picked at position 0
    walk("R1", '0, 1'b0, 0, 0, 0, 2, 0, 0);
  endtask

  task automatic t_touch_order;
    do_touch(0, 1'b0);
    // R2: frame 1 now least recent, read touch left frame 0 clean
    walk("R2", '0, 1'b0, 1, 0, 0, 2, 0, 0);
  endtask

  task automatic t_load_dirty;
    for (int f = 0; f < N; f++) do_fill(f, f, 1'b1);
    // R6: blk 0 has a cluster
    walk("R6", 16'h0001, 1'b0, 0, 1, 0, 2, 0, 0);
    // R7: no cluster but creation allowed
    walk("R7", '0, 1'b1, 0, 1, 0, 2, 0, 0);
    // R8 R4: frames 0..2 skipped, frame 3 (blk 3 resident) chosen at k=3
    walk("R8", 16'h0008, 1'b0, 3, 1, 3, 5, 0, 0);
    // R9: every dirty frame skipped, LRU forced
    walk("R9", '0, 1'b0, 0, 1, 0, 9, 0, 0);
  endtask

  task automatic t_wbdone;
    do_wbdone(2);
    // R10 R5: frame 2 now clean, taken at position 2
    walk("R10", '0, 1'b0, 2, 0, 2, 4, 0, 0);
  endtask

  task automatic t_write_hit;
    do_touch(2, 1'b1);
    // R3 R2: order 0,1,3,4,5,6,7,2; frame 2 dirty again; blk 4 resident
    walk("R3", 16'h0010, 1'b0, 4, 1, 4, 5, 0, 0);
    walk("R3", '0, 1'b0, 0, 1, 0, 9, 0, 0);
  endtask

  task automatic t_fill_clean;
    do_fill(5, 9, 1'b0);
    // R3 R12: order 0,1,3,4,6,7,2,5; only frame 5 clean at position 7
    walk("R12", '0, 1'b0, 5, 0, 9, 9, 0, 0);
  endtask

  task automatic t_busy;
    do_fill(5, 5, 1'b1);
    // R11: touch of frame 0 mid-walk must not change LRU, all deferred
    walk("R11", '0, 1'b0, 0, 1, 0, 9, 1'b1, 0);
    chk("R11", "busy after walk", int'(busy), 0);
    // R11: fill and touch together, fill wins (frame 0 clean, touch of 1 dropped)
    @(negedge clk); fill = 1; fill_fr = 0; fill_blk = 0; fill_wr = 0;
    touch = 1; touch_fr = 1; touch_wr = 1;
    @(negedge clk); fill = 0; touch = 0; touch_wr = 0;
    // order 1,3,4,6,7,2,5,0; frame 1 stays least recent, dirty
    walk("R11", 16'h0002, 1'b0, 1, 1, 1, 2, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_touch_order;
    t_load_dirty;
    t_wbdone;
    t_write_hit;
    t_fill_clean;
    t_busy;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule